// File: doc/BRIEF.md
# Inter-Processor Interrupt Flag Register Bank

This block lets any bus master signal any of a set of processor cores. Each core has a pair of registers. The first is a raise register. The second is a retire register. The pair shares one set of 28 source flags, and software decides what each flag means. A sender writes ones into the flag field of the raise register and can set bit 0 in the same write. Bit 0 fires a one-cycle interrupt pulse to that core. The receiving core reads either register of the pair to see which sources are pending. It then writes ones into the retire register to drop the flags it has handled.

Each core also has a third register, a write-only trigger. Writing 1 to its bit 0 sends a one-cycle non-maskable interrupt pulse to the core. The bus has address, write enable, write data, read enable and read data, with a single-cycle access. Read data is registered and appears in the cycle after the read is presented.

Top module: `ipc_flag_bank`

## Requirements
- R1: The bank uses byte addresses in 4-byte words. The trigger register of core x is at 4*x. The raise register of core x is at 4*NUM_CORES + 4*x. The retire register of core x is at 8*NUM_CORES + 4*x. With the defaults these are 0x00–0x0C, 0x10–0x1C and 0x20–0x2C. At most one interrupt pulse is high in any cycle.
- R2: Writing a word with bit 0 = 1 to the raise register of core x drives `irq_pulse[x]` high for the one cycle that follows the write edge. Bit 0 = 0 gives no pulse. Bits 3:1 never give a pulse.
- R3: Each bit of write-data field 31:4 that is 1, written to the raise register of core x, sets the matching flag of core x. Bits written as 0 leave their flags unchanged.
- R4: Each bit of write-data field 31:4 that is 1, written to the retire register of core x, clears the matching flag of core x. Bits written as 0 leave their flags unchanged. Bits 3:0 of such a write produce no pulse.
- R5: A read of either the raise or the retire register of core x returns the flags of core x in bits 31:4 and zero in bits 3:0. The data appears on `rd_data` in the cycle after `rd_en` is high. `rd_data` is zero in the cycle after a cycle with `rd_en` low.
- R6: Writing a word with bit 0 = 1 to the trigger register of core x drives `nmi_pulse[x]` high for the one cycle after the write edge. Bit 0 = 0 gives no pulse. A read of a trigger register returns zero.
- R7: After reset all flags are 0 and both pulse outputs are 0.
- R8: A single raise write that sets flags and bit 0 together updates the flags at the same edge that starts the pulse. A read presented in the pulse cycle therefore already returns the new flags.
- R9: An access to an address outside R1, including a non-word-aligned one, reads zero, changes no flag and produces no pulse.
- R10: Qualifying writes in consecutive cycles each produce their own one-cycle pulse, so the pulse stays high for as many cycles as there were writes.
- R11: An access to the registers of one core never changes the flags or pulses of another core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (8) | Byte address of the access |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for this cycle |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_pulse | output | NUM_CORES (4) | One-cycle interrupt pulse per core |
| nmi_pulse | output | NUM_CORES (4) | One-cycle non-maskable interrupt pulse per core |

## Verification
On every cycle the assertions check four things for each core. A qualifying raise or trigger write is followed by its pulse, and no pulse appears without one. A raise write leaves every written 1 set. A retire write leaves every written 1 clear. Flags hold still unless their own pair is written. They also check that the reserved read bits stay zero and that an idle read port returns zero. The directed scenarios must cover what a property cannot judge without a model of the whole bank. That covers the exact read value of each register through both addresses. It also covers misaligned and unmapped accesses, and the ordering of the combined set-and-pulse write. It includes back-to-back pulses and the isolation of one core from the others.

// File: rtl/ipc_flag_pkg.sv
package ipc_flag_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned SRC_LSB    = 4;
  localparam int unsigned SRC_W      = REG_W - SRC_LSB;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    BANK_NMI = 2'd0,
    BANK_GEN = 2'd1,
    BANK_ACK = 2'd2
  } bank_e;

  // Byte address of register idx inside bank b
  function automatic int unsigned reg_addr(bank_e b, int unsigned idx, int unsigned ncores);
    return (int'(b) * ncores + idx) * WORD_BYTES;
  endfunction

  // Next flag value given a set strobe, a clear strobe and the written field
  function automatic logic [SRC_W-1:0] flag_next(logic [SRC_W-1:0] cur,
                                                 logic [SRC_W-1:0] wfield,
                                                 logic set_en, logic clr_en);
    logic [SRC_W-1:0] nxt;
    nxt = cur;
    if (set_en) nxt = nxt | wfield;
    if (clr_en) nxt = nxt & ~wfield;
    return nxt;
  endfunction

  // Place the flags in a register word, reserved low bits zero
  function automatic logic [REG_W-1:0] pack_flags(logic [SRC_W-1:0] f);
    return {f, {SRC_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/ipc_addr_decode.sv
module ipc_addr_decode
  import ipc_flag_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_CORES-1:0] nmi_hit,
  output logic [NUM_CORES-1:0] gen_hit,
  output logic [NUM_CORES-1:0] ack_hit
);
  // R1 / R9: exact compare, so misaligned and unmapped addresses hit nothing
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] NMI_A = ADDR_W'(reg_addr(BANK_NMI, unsigned'(i), NUM_CORES));
    localparam logic [ADDR_W-1:0] GEN_A = ADDR_W'(reg_addr(BANK_GEN, unsigned'(i), NUM_CORES));
    localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(reg_addr(BANK_ACK, unsigned'(i), NUM_CORES));
    assign nmi_hit[i] = (addr == NMI_A);
    assign gen_hit[i] = (addr == GEN_A);
    assign ack_hit[i] = (addr == ACK_A);
  end
endmodule

// File: rtl/ipc_src_flags.sv
module ipc_src_flags
  import ipc_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] wfield,
  output logic [SRC_W-1:0] flags
);
  // R3 / R4 / R7
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flag_next(flags, wfield, set_en, clr_en);
  end
endmodule

// File: rtl/ipc_pulse_reg.sv
module ipc_pulse_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe,
  output logic [N-1:0] pulse
);
  // R2 / R6 / R10: one registered cycle per strobe cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= '0;
    else        pulse <= strobe;
  end
endmodule

// File: rtl/ipc_read_mux.sv
module ipc_read_mux
  import ipc_flag_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_en,
  input  logic [NUM_CORES-1:0]              sel,
  input  logic [NUM_CORES-1:0][SRC_W-1:0]   flags,
  output logic [REG_W-1:0]                  rd_data
);
  logic [REG_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (sel[i]) word = word | pack_flags(flags[i]);
    end
  end

  // R5: registered read, zero when idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= word;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/ipc_flag_bank.sv
module ipc_flag_bank
  import ipc_flag_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 rd_en,
  output logic [REG_W-1:0]     rd_data,
  output logic [NUM_CORES-1:0] irq_pulse,
  output logic [NUM_CORES-1:0] nmi_pulse
);
  logic [NUM_CORES-1:0]            nmi_hit, gen_hit, ack_hit;
  logic [NUM_CORES-1:0]            gen_wr, ack_wr, nmi_wr;
  logic [NUM_CORES-1:0]            irq_strobe, nmi_strobe;
  logic [NUM_CORES-1:0]            pair_sel;
  logic [NUM_CORES-1:0][SRC_W-1:0] src_flags;
  logic [SRC_W-1:0]                wfield;
  logic                            trig_bit;

  assign wfield   = wr_data[REG_W-1:SRC_LSB];
  assign trig_bit = wr_data[0];

  ipc_addr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .nmi_hit(nmi_hit), .gen_hit(gen_hit), .ack_hit(ack_hit)
  );

  assign gen_wr     = gen_hit & {NUM_CORES{wr_en}};
  assign ack_wr     = ack_hit & {NUM_CORES{wr_en}};
  assign nmi_wr     = nmi_hit & {NUM_CORES{wr_en}};
  assign irq_strobe = gen_wr & {NUM_CORES{trig_bit}};   // R2, R8
  assign nmi_strobe = nmi_wr & {NUM_CORES{trig_bit}};   // R6
  assign pair_sel   = gen_hit | ack_hit;                // R5

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    ipc_src_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_en(gen_wr[i]), .clr_en(ack_wr[i]),
      .wfield(wfield), .flags(src_flags[i])
    );
  end

  ipc_pulse_reg #(.N(NUM_CORES)) u_irq (
    .clk(clk), .rst_n(rst_n), .strobe(irq_strobe), .pulse(irq_pulse)
  );

  ipc_pulse_reg #(.N(NUM_CORES)) u_nmi (
    .clk(clk), .rst_n(rst_n), .strobe(nmi_strobe), .pulse(nmi_pulse)
  );

  ipc_read_mux #(.NUM_CORES(NUM_CORES)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(pair_sel),
    .flags(src_flags), .rd_data(rd_data)
  );
endmodule

// File: rtl/ipc_flag_bank_chk.sv
module ipc_flag_bank_chk
  import ipc_flag_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [ADDR_W-1:0]               addr,
  input logic                            wr_en,
  input logic [REG_W-1:0]                wr_data,
  input logic                            rd_en,
  input logic [REG_W-1:0]                rd_data,
  input logic [NUM_CORES-1:0]            irq_pulse,
  input logic [NUM_CORES-1:0]            nmi_pulse,
  input logic [NUM_CORES-1:0][SRC_W-1:0] src_flags
);
  AST_RD_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[SRC_LSB-1:0] == '0); // R5
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0); // R5
  AST_IRQ_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse)); // R1

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] NA = ADDR_W'(reg_addr(BANK_NMI, unsigned'(i), NUM_CORES));
    localparam logic [ADDR_W-1:0] GA = ADDR_W'(reg_addr(BANK_GEN, unsigned'(i), NUM_CORES));
    localparam logic [ADDR_W-1:0] AA = ADDR_W'(reg_addr(BANK_ACK, unsigned'(i), NUM_CORES));

    AST_IRQ_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == GA && wr_data[0]) |=> irq_pulse[i]); // R10
    AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[i] |-> $past(wr_en && addr == GA && wr_data[0])); // R2
    AST_NMI_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == NA && wr_data[0]) |=> nmi_pulse[i]); // R6
    AST_NMI_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pulse[i] |-> $past(wr_en && addr == NA && wr_data[0])); // R6
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == GA) |=>
        ((src_flags[i] & $past(wr_data[REG_W-1:SRC_LSB])) == $past(wr_data[REG_W-1:SRC_LSB]))); // R3
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AA) |=>
        ((src_flags[i] & $past(wr_data[REG_W-1:SRC_LSB])) == '0)); // R4
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (addr == GA || addr == AA)) |=> $stable(src_flags[i])); // R11
  end
endmodule

bind ipc_flag_bank ipc_flag_bank_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .irq_pulse(irq_pulse), .nmi_pulse(nmi_pulse),
  .src_flags(src_flags)
);

// File: tb/ipc_flag_bank_bench.sv
module ipc_flag_bank_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [3:0]  irq_pulse, nmi_pulse;

  int n_checks = 0;
  int n_errors = 0;
  logic [27:0] m_flags [4];

  always #2.5 clk = ~clk;

  ipc_flag_bank u_ipc_flag_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_pulse(irq_pulse), .nmi_pulse(nmi_pulse)
  );

  function automatic logic [7:0] a_nmi(int x); return 8'(4 * x);      endfunction
  function automatic logic [7:0] a_gen(int x); return 8'(16 + 4 * x); endfunction
  function automatic logic [7:0] a_ack(int x); return 8'(32 + 4 * x); endfunction

  function automatic logic [31:0] read_model(logic [7:0] a);
    for (int x = 0; x < 4; x++)
      if (a == a_gen(x) || a == a_ack(x)) return {m_flags[x], 4'h0};
    return 32'h0;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d, string req);
    logic [3:0] e_irq = '0;
    logic [3:0] e_nmi = '0;
    for (int x = 0; x < 4; x++) begin
      if (a == a_gen(x)) begin
        e_irq[x] = d[0];
        m_flags[x] = m_flags[x] | d[31:4];
      end
      if (a == a_ack(x)) m_flags[x] = m_flags[x] & ~d[31:4];
      if (a == a_nmi(x)) e_nmi[x] = d[0];
    end
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    check(req, "irq pulse", {28'h0, irq_pulse}, {28'h0, e_irq});
    check(req, "nmi pulse", {28'h0, nmi_pulse}, {28'h0, e_nmi});
    wr_en = 1'b0; wr_data = '0;
    @(negedge clk);
    check(req, "irq after one cycle", {28'h0, irq_pulse}, 32'h0);
    check(req, "nmi after one cycle", {28'h0, nmi_pulse}, 32'h0);
  endtask

  task automatic do_read(logic [7:0] a, string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    check(req, "read data", rd_data, read_model(a));
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R7", "irq at reset", {28'h0, irq_pulse}, 32'h0);
    check("R7", "nmi at reset", {28'h0, nmi_pulse}, 32'h0);
    for (int x = 0; x < 4; x++) do_read(a_gen(x), "R7");
  endtask

  task automatic t_set();
    do_write(a_gen(1), 32'hA5A5_0000, "R3");
    do_read(a_gen(1), "R3");
    do_write(a_gen(1), 32'h0F00_00F0, "R3");
    do_read(a_ack(1), "R5");
    do_write(a_gen(1), 32'h0, "R3");
    do_read(a_gen(1), "R3");
  endtask

  task automatic t_clear();
    do_write(a_ack(1), 32'h0000_FFF0, "R4");
    do_read(a_ack(1), "R4");
    do_write(a_ack(1), 32'h0000_000F, "R4");
    do_read(a_gen(1), "R4");
  endtask

  task automatic t_irq();
    do_write(a_gen(2), 32'h1, "R2");
    do_write(a_gen(2), 32'hE, "R2");
    do_read(a_gen(2), "R5");
  endtask

  task automatic t_nmi();
    do_write(a_nmi(3), 32'h1, "R6");
    do_write(a_nmi(3), 32'hFFFF_FFFF, "R6");
    do_write(a_nmi(0), 32'hFFFF_FFFE, "R6");
    do_read(a_nmi(3), "R6");
  endtask

  task automatic t_combined();
    m_flags[0] = m_flags[0] | 28'h800_0001;
    @(negedge clk);
    addr = a_gen(0); wr_data = 32'h8000_0011; wr_en = 1'b1;
    @(negedge clk);
    check("R8", "pulse in combined write", {28'h0, irq_pulse}, 32'h1);
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b1;
    @(negedge clk);
    check("R8", "flags seen by read in pulse cycle", rd_data, {m_flags[0], 4'h0});
    check("R8", "pulse ended", {28'h0, irq_pulse}, 32'h0);
    rd_en = 1'b0;
  endtask

  task automatic t_unmapped();
    do_write(8'h11, 32'hFFFF_FFFF, "R9");
    do_write(8'h30, 32'hFFFF_FFFF, "R9");
    do_write(8'hFC, 32'hFFFF_FFFF, "R9");
    do_write(8'h22, 32'hFFFF_FFF0, "R9");
    do_read(8'h11, "R9");
    do_read(8'h30, "R9");
    for (int x = 0; x < 4; x++) do_read(a_gen(x), "R9");
  endtask

  task automatic t_b2b();
    @(negedge clk);
    addr = a_gen(3); wr_data = 32'h1; wr_en = 1'b1;
    @(negedge clk);
    check("R10", "first pulse", {28'h0, irq_pulse}, 32'h8);
    @(negedge clk);
    check("R10", "second pulse", {28'h0, irq_pulse}, 32'h8);
    wr_en = 1'b0; wr_data = '0;
    @(negedge clk);
    check("R10", "after two pulses", {28'h0, irq_pulse}, 32'h0);
  endtask

  task automatic t_isolation();
    do_write(a_gen(3), 32'hFFFF_FFF1, "R11");
    for (int x = 0; x < 4; x++) do_read(a_ack(x), "R11");
    do_write(a_ack(3), 32'hFFFF_FFF0, "R11");
    for (int x = 0; x < 4; x++) do_read(a_gen(x), "R11");
  endtask

  task automatic t_idle_read();
    do_read(a_gen(0), "R5");
    @(negedge clk);
    check("R5", "idle read port", rd_data, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int x = 0; x < 4; x++) m_flags[x] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set();
    t_clear();
    t_irq();
    t_nmi();
    t_combined();
    t_unmapped();
    t_b2b();
    t_isolation();
    t_idle_read();
    do_read(a_gen(1), "R1");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule